// File: doc/BRIEF.md
# Debug Halt/Resume Handshake Memory

This block is a small memory-mapped slave region that sits inside a debug module. A halted hart runs a fixed polling loop. On each pass it reports its own hart ID as halted, reads a per-hart flag byte, and then either acknowledges a GO request and jumps through a one-word trampoline, or acknowledges a RESUME request and leaves debug mode. The hart talks to the block over a simple word-wide bus with a one-cycle read latency. Each acknowledge is a write of the hart ID to its own dedicated address.

The debugger side has a control port. On it the debugger hands GO to one halted hart, together with a 2-bit choice of where that hart should jump. It can also request RESUME for any set of halted harts at once, and clear the exception indication. The trampoline word is a jump-and-link encoding with a zero destination register. The block computes it from fixed region addresses and latches the choice when GO is granted, so the word is always in place before the hart can see GO.

Top module: `dbg_handshake_mem`

## Requirements
- R1: A read of byte address FLAGS_BASE + h (0x400 + h by default, with h below NUM_HARTS) returns the flag byte of hart h in bits 7:0, with zeros above. In that byte, bit 0 is the GO flag and bit 1 is the RESUME flag.
- R2: A bus write of value h to the HALTED address (0x100) marks hart h as halted. Repeating the write leaves the state unchanged. A value of NUM_HARTS or more is ignored.
- R3: A bus write of value h to the GOING address (0x104) clears the GO flag of hart h.
- R4: A bus write of value h to the RESUMING address (0x108) clears the RESUME flag and the halted state of hart h, and sets the resume-acknowledge status of hart h.
- R5: Any bus write to the EXCEPTION address (0x10C) sets the exception output on the next cycle. ctlExcClear clears it, and the clear wins when both happen in the same cycle.
- R6: A GO request is accepted only if the selected hart is halted and no GO flag is set for any hart. Any other GO request has no effect. At most one GO flag is ever set.
- R7: A RESUME request sets the RESUME flag and clears resume-acknowledge, but only for the harts in the mask that are halted. Bits for harts that are not halted are ignored.
- R8: A read of the WHERETO address (0x300) returns a JAL x0 word whose offset is the target minus 0x300. Code 0 selects the abstract area at 0x338 (0x0380006F). Code 1 selects the program buffer at 0x344 (0x0440006F). Codes 2 and 3 select the resume entry at 0x804 (0x5040006F). The code is latched when a GO request is accepted, and resets to the resume entry.
- R9: busRvalid is high exactly one cycle after each read request. busRdata shows the state before that cycle's updates. Reads of unmapped or write-only addresses return zero.
- R10: After reset, all halted, GO, RESUME and acknowledge state and the exception output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus request valid |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data (hart ID for acknowledges) |
| busRdata | output | 32 | Read data, one cycle after request |
| busRvalid | output | 1 | Read data valid |
| ctlGoReq | input | 1 | Debugger GO request |
| ctlHartSel | input | HID_W | Hart addressed by GO |
| ctlTarget | input | 2 | Trampoline target code for GO |
| ctlResumeReq | input | 1 | Debugger RESUME request |
| ctlResumeMask | input | NUM_HARTS | Harts addressed by RESUME |
| ctlExcClear | input | 1 | Clear the exception indication |
| haltedOut | output | NUM_HARTS | Per-hart halted state |
| resumeAckOut | output | NUM_HARTS | Per-hart resume-acknowledge |
| excOut | output | 1 | Exception indication |

## Verification
The assertions assume at most one bus transaction per cycle, and assume that bus and control inputs are free of X after reset. The stimulus drives a single request per cycle, in the falling half of the clock. It includes acknowledge writes with out-of-range IDs and GO/RESUME requests aimed at harts that are not halted, so the ignore rules get exercised. A behavioural model in the bench mirrors the flag, halted, acknowledge and trampoline state. It is compared against every output after each edge, including reads issued in the same cycle as state changes.

// File: rtl/dbgh_pkg.sv
`timescale 1ns/1ps
package dbgh_pkg;

  typedef struct packed {
    logic haltedWr;
    logic goingWr;
    logic resumingWr;
    logic excWr;
    logic excClr;
    logic goSet;
    logic rdFlags;
    logic rdWhereto;
    logic rdAny;
  } dbgh_strobe_t;

  localparam logic [1:0] TGT_ABSTRACT = 2'd0;
  localparam logic [1:0] TGT_PROGBUF  = 2'd1;
  localparam logic [1:0] TGT_RESUME   = 2'd2;

  // JAL with rd = x0; imm scrambled into bits 31:12
  function automatic logic [31:0] jalX0(input logic [20:0] off);
    return {off[20], off[10:1], off[11], off[19:12], 5'd0, 7'h6F};
  endfunction

endpackage

// File: rtl/dbgh_ctrl.sv
`timescale 1ns/1ps
module dbgh_ctrl
  import dbgh_pkg::*;
#(
  parameter int NUM_HARTS     = 4,
  parameter int ADDR_W        = 12,
  parameter int HALTED_ADDR   = 'h100,
  parameter int GOING_ADDR    = 'h104,
  parameter int RESUMING_ADDR = 'h108,
  parameter int EXC_ADDR      = 'h10C,
  parameter int WHERETO_ADDR  = 'h300,
  parameter int FLAGS_BASE    = 'h400,
  localparam int HID_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  input  logic                 ctlGoReq,
  input  logic [HID_W-1:0]     ctlHartSel,
  input  logic                 ctlResumeReq,
  input  logic [NUM_HARTS-1:0] ctlResumeMask,
  input  logic                 ctlExcClear,
  input  logic [NUM_HARTS-1:0] haltedQ,
  input  logic [NUM_HARTS-1:0] goQ,
  output dbgh_strobe_t         stb,
  output logic [HID_W-1:0]     ackId,
  output logic [HID_W-1:0]     goId,
  output logic [NUM_HARTS-1:0] resumeMask,
  output logic [HID_W-1:0]     rdIdx
);

  logic wrEn, rdEn, idOk, selOk, inFlags;
  logic [ADDR_W-1:0] flagOff;

  assign wrEn    = busValid && busWrite;
  assign rdEn    = busValid && !busWrite;
  assign idOk    = busWdata < 32'(NUM_HARTS);
  assign ackId   = busWdata[HID_W-1:0];
  assign flagOff = busAddr - ADDR_W'(FLAGS_BASE);
  assign inFlags = flagOff < ADDR_W'(NUM_HARTS);
  assign rdIdx   = flagOff[HID_W-1:0];
  assign goId    = ctlHartSel;

  generate
    if ((1 << HID_W) == NUM_HARTS) begin : gSelFull
      assign selOk = 1'b1;
    end else begin : gSelPart
      assign selOk = {{(32-HID_W){1'b0}}, ctlHartSel} < 32'(NUM_HARTS);
    end
  endgenerate

  always_comb begin
    stb            = '0;
    stb.haltedWr   = wrEn && idOk && (busAddr == ADDR_W'(HALTED_ADDR));
    stb.goingWr    = wrEn && idOk && (busAddr == ADDR_W'(GOING_ADDR));
    stb.resumingWr = wrEn && idOk && (busAddr == ADDR_W'(RESUMING_ADDR));
    stb.excWr      = wrEn && (busAddr == ADDR_W'(EXC_ADDR));
    stb.excClr     = ctlExcClear;
    stb.goSet      = ctlGoReq && selOk && haltedQ[ctlHartSel] && (goQ == '0);
    stb.rdAny      = rdEn;
    stb.rdFlags    = rdEn && inFlags;
    stb.rdWhereto  = rdEn && (busAddr == ADDR_W'(WHERETO_ADDR));
    resumeMask     = ctlResumeReq ? (ctlResumeMask & haltedQ) : '0;
  end

endmodule

// File: rtl/dbgh_datapath.sv
`timescale 1ns/1ps
module dbgh_datapath
  import dbgh_pkg::*;
#(
  parameter int NUM_HARTS     = 4,
  parameter int WHERETO_ADDR  = 'h300,
  parameter int ABSTRACT_ADDR = 'h338,
  parameter int PROGBUF_ADDR  = 'h344,
  parameter int RESUME_ADDR   = 'h804,
  localparam int HID_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dbgh_strobe_t         stb,
  input  logic [HID_W-1:0]     ackId,
  input  logic [HID_W-1:0]     goId,
  input  logic [NUM_HARTS-1:0] resumeMask,
  input  logic [HID_W-1:0]     rdIdx,
  input  logic [1:0]           ctlTarget,
  output logic [NUM_HARTS-1:0] haltedQ,
  output logic [NUM_HARTS-1:0] goQ,
  output logic [NUM_HARTS-1:0] ackQ,
  output logic                 excQ,
  output logic                 rvalidQ,
  output logic [31:0]          rdataQ
);

  localparam int OFF_ABS = ABSTRACT_ADDR - WHERETO_ADDR;
  localparam int OFF_PB  = PROGBUF_ADDR - WHERETO_ADDR;
  localparam int OFF_RES = RESUME_ADDR - WHERETO_ADDR;

  logic [NUM_HARTS-1:0] resQ;
  logic [1:0]           targetQ;
  logic [7:0]           flagByte [NUM_HARTS];
  logic [31:0]          wheretoWord;

  genvar g;
  generate
    for (g = 0; g < NUM_HARTS; g++) begin : gFlag
      assign flagByte[g] = {6'd0, resQ[g], goQ[g]};
    end
  endgenerate

  always_comb begin
    case (targetQ)
      TGT_ABSTRACT: wheretoWord = jalX0(21'(OFF_ABS));
      TGT_PROGBUF:  wheretoWord = jalX0(21'(OFF_PB));
      default:      wheretoWord = jalX0(21'(OFF_RES));
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haltedQ <= '0;
      goQ     <= '0;
      resQ    <= '0;
      ackQ    <= '0;
      excQ    <= 1'b0;
      targetQ <= TGT_RESUME;
      rvalidQ <= 1'b0;
      rdataQ  <= '0;
    end else begin
      for (int i = 0; i < NUM_HARTS; i++) begin
        if (stb.haltedWr && ackId == HID_W'(i)) haltedQ[i] <= 1'b1;
        if (stb.goSet && goId == HID_W'(i)) goQ[i] <= 1'b1;
        if (stb.goingWr && ackId == HID_W'(i)) goQ[i] <= 1'b0;
        if (resumeMask[i]) begin
          resQ[i] <= 1'b1;
          ackQ[i] <= 1'b0;
        end
        if (stb.resumingWr && ackId == HID_W'(i)) begin
          resQ[i]    <= 1'b0;
          haltedQ[i] <= 1'b0;
          ackQ[i]    <= 1'b1;
        end
      end
      if (stb.goSet) targetQ <= ctlTarget;
      if (stb.excWr) excQ <= 1'b1;
      if (stb.excClr) excQ <= 1'b0;
      rvalidQ <= stb.rdAny;
      if (stb.rdFlags)        rdataQ <= {24'd0, flagByte[rdIdx]};
      else if (stb.rdWhereto) rdataQ <= wheretoWord;
      else                    rdataQ <= '0;
    end
  end

endmodule

// File: rtl/dbg_handshake_mem.sv
`timescale 1ns/1ps
module dbg_handshake_mem
  import dbgh_pkg::*;
#(
  parameter int NUM_HARTS     = 4,
  parameter int ADDR_W        = 12,
  parameter int HALTED_ADDR   = 'h100,
  parameter int GOING_ADDR    = 'h104,
  parameter int RESUMING_ADDR = 'h108,
  parameter int EXC_ADDR      = 'h10C,
  parameter int WHERETO_ADDR  = 'h300,
  parameter int ABSTRACT_ADDR = 'h338,
  parameter int PROGBUF_ADDR  = 'h344,
  parameter int RESUME_ADDR   = 'h804,
  parameter int FLAGS_BASE    = 'h400,
  localparam int HID_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic                 busRvalid,
  input  logic                 ctlGoReq,
  input  logic [HID_W-1:0]     ctlHartSel,
  input  logic [1:0]           ctlTarget,
  input  logic                 ctlResumeReq,
  input  logic [NUM_HARTS-1:0] ctlResumeMask,
  input  logic                 ctlExcClear,
  output logic [NUM_HARTS-1:0] haltedOut,
  output logic [NUM_HARTS-1:0] resumeAckOut,
  output logic                 excOut
);

  dbgh_strobe_t         stb;
  logic [HID_W-1:0]     ackId, goId, rdIdx;
  logic [NUM_HARTS-1:0] resumeMask, haltedQ, goQ;

  dbgh_ctrl #(
    .NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W),
    .HALTED_ADDR(HALTED_ADDR), .GOING_ADDR(GOING_ADDR),
    .RESUMING_ADDR(RESUMING_ADDR), .EXC_ADDR(EXC_ADDR),
    .WHERETO_ADDR(WHERETO_ADDR), .FLAGS_BASE(FLAGS_BASE)
  ) uCtrl (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .ctlGoReq(ctlGoReq), .ctlHartSel(ctlHartSel),
    .ctlResumeReq(ctlResumeReq), .ctlResumeMask(ctlResumeMask),
    .ctlExcClear(ctlExcClear), .haltedQ(haltedQ), .goQ(goQ),
    .stb(stb), .ackId(ackId), .goId(goId), .resumeMask(resumeMask),
    .rdIdx(rdIdx)
  );

  dbgh_datapath #(
    .NUM_HARTS(NUM_HARTS), .WHERETO_ADDR(WHERETO_ADDR),
    .ABSTRACT_ADDR(ABSTRACT_ADDR), .PROGBUF_ADDR(PROGBUF_ADDR),
    .RESUME_ADDR(RESUME_ADDR)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .ackId(ackId), .goId(goId),
    .resumeMask(resumeMask), .rdIdx(rdIdx), .ctlTarget(ctlTarget),
    .haltedQ(haltedQ), .goQ(goQ), .ackQ(resumeAckOut), .excQ(excOut),
    .rvalidQ(busRvalid), .rdataQ(busRdata)
  );

  assign haltedOut = haltedQ;

endmodule

// File: rtl/dbgh_checker.sv
`timescale 1ns/1ps
module dbgh_checker #(
  parameter int NUM_HARTS     = 4,
  parameter int ADDR_W        = 12,
  parameter int HALTED_ADDR   = 'h100,
  parameter int RESUMING_ADDR = 'h108,
  parameter int EXC_ADDR      = 'h10C,
  parameter int WHERETO_ADDR  = 'h300,
  parameter int FLAGS_BASE    = 'h400,
  localparam int HID_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busValid,
  input logic                 busWrite,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [31:0]          busWdata,
  input logic                 busRvalid,
  input logic [31:0]          busRdata,
  input logic                 ctlExcClear,
  input logic [NUM_HARTS-1:0] haltedOut,
  input logic [NUM_HARTS-1:0] goQ,
  input logic                 excOut
);

  logic rdReq, unmapped, idOk;
  logic [ADDR_W-1:0] off;
  assign rdReq    = busValid && !busWrite;
  assign off      = busAddr - ADDR_W'(FLAGS_BASE);
  assign unmapped = !(off < ADDR_W'(NUM_HARTS)) && busAddr != ADDR_W'(WHERETO_ADDR);
  assign idOk     = busWdata < 32'(NUM_HARTS);

  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(goQ)); // R6
  AST_GO_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((goQ & ~$past(goQ) & ~$past(haltedOut)) == '0)); // R6
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> busRvalid); // R9
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> !busRvalid); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && unmapped |=> busRdata == 32'd0); // R9
  AST_EXC_SET: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busWrite && busAddr == ADDR_W'(EXC_ADDR) && !ctlExcClear |=> excOut); // R5
  AST_EXC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ctlExcClear |=> !excOut); // R5
  AST_HALTED_SET: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busWrite && busAddr == ADDR_W'(HALTED_ADDR) && idOk
    |=> haltedOut[$past(busWdata[HID_W-1:0])]); // R2
  AST_RESUMING_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busWrite && busAddr == ADDR_W'(RESUMING_ADDR) && idOk
    |=> !haltedOut[$past(busWdata[HID_W-1:0])]); // R4

endmodule

bind dbg_handshake_mem dbgh_checker #(
  .NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W), .HALTED_ADDR(HALTED_ADDR),
  .RESUMING_ADDR(RESUMING_ADDR), .EXC_ADDR(EXC_ADDR),
  .WHERETO_ADDR(WHERETO_ADDR), .FLAGS_BASE(FLAGS_BASE)
) uChk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busRvalid(busRvalid),
  .busRdata(busRdata), .ctlExcClear(ctlExcClear), .haltedOut(haltedOut),
  .goQ(goQ), .excOut(excOut)
);

// File: tb/sim_dbg_handshake_mem.sv
`timescale 1ns/1ps
module sim_dbg_handshake_mem;
  localparam int N = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, busValid, busWrite, busRvalid, ctlGoReq, ctlResumeReq, ctlExcClear, excOut;
  logic [11:0] busAddr;
  logic [31:0] busWdata, busRdata;
  logic [1:0] ctlHartSel, ctlTarget;
  logic [N-1:0] ctlResumeMask, haltedOut, resumeAckOut;

  dbg_handshake_mem u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busRvalid(busRvalid), .ctlGoReq(ctlGoReq), .ctlHartSel(ctlHartSel),
    .ctlTarget(ctlTarget), .ctlResumeReq(ctlResumeReq),
    .ctlResumeMask(ctlResumeMask), .ctlExcClear(ctlExcClear),
    .haltedOut(haltedOut), .resumeAckOut(resumeAckOut), .excOut(excOut)
  );

  int compared = 0, mismatched = 0;
  bit mHalted[N], mGo[N], mRes[N], mAck[N];
  bit mExc, mRvalid;
  int mTgt;
  logic [31:0] mRdata;

  function automatic logic [31:0] jalFor(int t);
    if (t == 0) return 32'h0380006F;
    if (t == 1) return 32'h0440006F;
    return 32'h5040006F;
  endfunction

  function automatic logic [N-1:0] vec(bit a[N]);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = a[i];
    return v;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    busValid = 0; busWrite = 0; busAddr = '0; busWdata = '0;
    ctlGoReq = 0; ctlHartSel = '0; ctlTarget = '0;
    ctlResumeReq = 0; ctlResumeMask = '0; ctlExcClear = 0;
  endtask

  task automatic modelStep();
    bit anyGo, goAcc;
    bit rmask[N];
    int a, w, s;
    a = int'(busAddr); w = int'(busWdata); s = int'(ctlHartSel);
    mRvalid = busValid && !busWrite;
    mRdata = '0;
    if (mRvalid) begin
      if (a >= 'h400 && a < 'h400 + N) mRdata = {30'd0, mRes[a-'h400], mGo[a-'h400]};
      else if (a == 'h300) mRdata = jalFor(mTgt);
    end
    anyGo = 0;
    for (int i = 0; i < N; i++) anyGo |= mGo[i];
    goAcc = ctlGoReq && mHalted[s] && !anyGo;
    for (int i = 0; i < N; i++) rmask[i] = ctlResumeReq && ctlResumeMask[i] && mHalted[i];
    if (goAcc) begin mGo[s] = 1; mTgt = int'(ctlTarget); end
    for (int i = 0; i < N; i++) if (rmask[i]) begin mRes[i] = 1; mAck[i] = 0; end
    if (busValid && busWrite) begin
      if (busWdata < N) begin
        if (a == 'h100) mHalted[w] = 1;
        if (a == 'h104) mGo[w] = 0;
        if (a == 'h108) begin mRes[w] = 0; mHalted[w] = 0; mAck[w] = 1; end
      end
      if (a == 'h10C) mExc = 1;
    end
    if (ctlExcClear) mExc = 0;
  endtask

  task automatic compareAll(string tag);
    chk(tag, "rvalid", 32'(busRvalid), 32'(mRvalid));
    chk(tag, "rdata", busRdata, mRdata);
    chk(tag, "halted", 32'(haltedOut), 32'(vec(mHalted)));
    chk(tag, "resumeAck", 32'(resumeAckOut), 32'(vec(mAck)));
    chk(tag, "exc", 32'(excOut), 32'(mExc));
  endtask

  task automatic tick(string tag);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
    idle();
  endtask

  task automatic wr(int addr, int data, string tag);
    busValid = 1; busWrite = 1; busAddr = 12'(addr); busWdata = 32'(data);
    tick(tag);
  endtask

  task automatic rd(int addr, string tag);
    busValid = 1; busWrite = 0; busAddr = 12'(addr);
    tick(tag);
  endtask

  task automatic go(int h, int t, string tag);
    ctlGoReq = 1; ctlHartSel = 2'(h); ctlTarget = 2'(t);
    tick(tag);
  endtask

  task automatic resume(int mask, string tag);
    ctlResumeReq = 1; ctlResumeMask = N'(mask);
    tick(tag);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    idle();
    rstN = 0;
    mTgt = 2; mExc = 0; mRvalid = 0; mRdata = '0;
    for (int i = 0; i < N; i++) begin mHalted[i] = 0; mGo[i] = 0; mRes[i] = 0; mAck[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    compareAll("R10");                   // R10 reset state
    rd('h300, "R8");                     // R8 reset target = resume entry
    rd('h400, "R1");                     // R1 empty flags
    go(1, 0, "R6");                      // R6 hart 1 not halted: ignored
    rd('h401, "R6");
    resume('hF, "R7");                   // R7 nobody halted: ignored
    rd('h400, "R7");
    wr('h100, 1, "R2");                  // R2 halted
    wr('h100, 2, "R2");
    wr('h100, 1, "R2");                  // R2 repeat
    wr('h100, 9, "R2");                  // R2 out-of-range id ignored
    go(1, 1, "R6");                      // R6 accepted
    rd('h401, "R1");                     // R1 GO in bit 0
    rd('h300, "R8");                     // R8 program buffer jump
    go(2, 0, "R6");                      // R6 GO already pending: ignored
    rd('h402, "R6");
    rd('h300, "R8");                     // R8 target unchanged
    wr('h104, 1, "R3");                  // R3 going
    rd('h401, "R3");
    go(2, 0, "R6");
    rd('h300, "R8");                     // R8 abstract jump
    wr('h104, 2, "R3");
    go(3, 1, "R6");                      // R6 hart 3 never halted
    resume('h7, "R7");                   // R7 harts 1,2 only
    rd('h401, "R1");                     // R1 RESUME in bit 1
    rd('h402, "R7");
    rd('h400, "R7");
    wr('h108, 1, "R4");                  // R4 resuming
    rd('h401, "R4");
    wr('h10C, 0, "R5");                  // R5 exception set
    rd('h10C, "R9");                     // R9 write-only reads zero
    ctlExcClear = 1; tick("R5");         // R5 clear
    busValid = 1; busWrite = 1; busAddr = 12'h10C; busWdata = '0;
    ctlExcClear = 1; tick("R5");         // R5 clear wins
    rd('h100, "R9");
    rd('h7FC, "R9");                     // R9 unmapped
    rd('h404, "R9");                     // R9 past the flag bytes
    wr('h100, 1, "R2");
    resume('h2, "R7");                   // R7 re-request clears ack
    busValid = 1; busWrite = 0; busAddr = 12'h401;
    ctlGoReq = 1; ctlHartSel = 2'd1; ctlTarget = 2'd3;
    tick("R9");                          // R9 read shows pre-update state
    rd('h401, "R1");
    rd('h300, "R8");                     // R8 code 3 = resume entry
    wr('h104, 1, "R3");
    wr('h108, 2, "R4");
    wr('h108, 1, "R4");
    repeat (2) tick("R9");
    summary();
    $finish;
  end
endmodule